// File: doc/BRIEF.md
# Multi-Channel Consecutive Alert Filter

This block sits after the converter of a multi-channel remote temperature sensor. It decides when the two open alarm outputs may fire. After each conversion it receives one measurement strobe. The strobe carries the channel index, the measured reading, a diode-fault flag and the high, low and thermal limits that apply to that channel. The block classifies the reading against those limits. It then advances or clears a debounce counter for that channel. There is one such counter for the interrupt-style alert output and a separate one for the thermal shutdown output.

An output is raised only after the programmed number of back-to-back bad readings on one channel. A reading from another channel does not count as a break in that run. Once the alert counter of a channel qualifies, the block latches sticky status bits that say which condition occurred: above the high limit, below the low limit, or diode fault. These bits stay set until a read-clear pulse. A diode fault is itself a bad reading. It forces the reported reading to zero, and no limit comparison is made on that measurement.

Top module: `temp_alert_filter`

## Requirements
- R1: A reading is above the high limit only when it is strictly greater than it, and below the low limit only when it is strictly smaller; a reading equal to either limit is a clean reading.
- R2: The 3-bit count selectors decode as 000 to 1, 001 to 2, 011 to 3 and 111 to 4 consecutive events; every other code means 1.
- R3: A channel's counter advances on each of its own bad readings in a row; readings of other channels neither advance nor clear it.
- R4: A clean reading of a channel (no limit violation, no diode fault) returns both of its counters to zero, and the outputs it was holding drop after that update.
- R5: A counter saturates at its threshold, and the output stays asserted while further bad readings of that channel arrive.
- R6: A diode fault counts as a bad reading for both counters. The reading reported one cycle later is zero, and neither the high-limit nor the low-limit comparison is made for that measurement.
- R7: `alert_mask[c]`=1 keeps channel c from driving `alert_o`; its counter and status bits still work, and clearing the mask bit exposes a qualified channel at once.
- R8: The thermal output uses its own per-channel counter, its own selector, and the condition "reading strictly above the thermal limit or diode fault"; it is independent of the alert counter.
- R9: On each measurement that qualifies a channel's alert counter, the high and low status bits of that channel latch the conditions seen on that measurement.
- R10: A diode fault that qualifies the alert counter sets that channel's bit in `fault_flags`, and `fault_any` is the OR of `fault_flags`.
- R11: `rd_clr` clears all status and fault bits at the next clock edge; a bit that is set on that same edge stays set.
- R12: After reset both outputs, all status and fault bits, `rpt_valid` and `rpt_value` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_valid | input | 1 | One-cycle strobe: a measurement is presented |
| meas_ch | input | $clog2(NCH) | Channel index of the measurement |
| meas_value | input | DW | Measured reading, unsigned |
| meas_fault | input | 1 | Diode fault detected on this measurement |
| hi_lim | input | DW | High limit for this channel |
| lo_lim | input | DW | Low limit for this channel |
| th_lim | input | DW | Thermal limit for this channel |
| alert_sel | input | 3 | Consecutive count selector for the alert output |
| therm_sel | input | 3 | Consecutive count selector for the thermal output |
| alert_mask | input | NCH | Per-channel alert mask, 1 = masked |
| rd_clr | input | 1 | Read-clear pulse for the status and fault bits |
| alert_o | output | 1 | Interrupt-style alert output, active high |
| therm_o | output | 1 | Thermal shutdown output, active high |
| rpt_valid | output | 1 | Reported reading valid, one cycle after the strobe |
| rpt_value | output | DW | Reported reading, zero on a diode fault |
| status_hi | output | NCH | Sticky high-limit status per channel |
| status_lo | output | NCH | Sticky low-limit status per channel |
| fault_flags | output | NCH | Sticky diode-fault flags per channel |
| fault_any | output | 1 | OR of the fault flags |

## Verification
The hardest case to reach from the ports is a run of bad readings on one channel with measurements of other channels placed between them. The strobes have to be interleaved so that the counter of one channel reaches its threshold while another channel's counter sits part-way. The stimulus alternates two channels under a threshold of two. It then cleans one channel and checks that the other channel's partial count does not raise the output. A second hard case is a read-clear on the same edge as a qualifying event. A task drives `rd_clr` and the strobe in the same cycle and then checks that only the newly set bit remains.

// File: rtl/tmp_alert_pkg.sv
// Package: shared types and the count-selector decode for the alert filter.
// Assumes the selector field is 3 bits wide and the thresholds stay at or below 4.
package tmp_alert_pkg;

    localparam int SEL_W = 3;
    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] MAX_THR = 3'd4;

    // Classification of one measurement.
    typedef struct packed {
        logic hi;   // strictly above high limit
        logic lo;   // strictly below low limit
        logic th;   // above thermal limit or diode fault
        logic flt;  // diode fault
    } evt_t;

    // Map the selector code to a consecutive-event threshold.
    function automatic logic [CNT_W-1:0] sel_to_thr(input logic [SEL_W-1:0] s);
        case (s)
            3'b001:  return 3'd2;
            3'b011:  return 3'd3;
            3'b111:  return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/limit_compare.sv
// Module: limit_compare
// Classifies one measurement against its limits. A diode fault suppresses
// both limit compares and forces the reported reading to zero.
// Assumes unsigned readings and limits of equal width.
module limit_compare
    import tmp_alert_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] value,
    input  logic          fault,
    input  logic [DW-1:0] hi_lim,
    input  logic [DW-1:0] lo_lim,
    input  logic [DW-1:0] th_lim,
    output evt_t          ev,
    output logic [DW-1:0] shown
);

    // Strict compares, gated by the fault flag.
    always_comb begin
        ev.flt = fault;
        ev.hi  = !fault && (value > hi_lim);
        ev.lo  = !fault && (value < lo_lim);
        ev.th  = fault || (value > th_lim);
        shown  = fault ? '0 : value;
    end

endmodule

// File: rtl/event_debounce.sv
// Module: event_debounce
// One consecutive-event counter for one channel and one output. It advances on
// each bad reading of its channel, clears on a clean one, and saturates at the
// decoded threshold. Assumes upd is high only for measurements of its channel.
module event_debounce
    import tmp_alert_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic             ev,
    input  logic [SEL_W-1:0] sel,
    output logic             hit_o,
    output logic             qual_o
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] thr;

    // Next count: advance, saturate or clear on an update.
    always_comb begin
        thr     = sel_to_thr(sel);
        cnt_nxt = cnt;
        if (upd) begin
            if (!ev)             cnt_nxt = '0;
            else if (cnt >= thr) cnt_nxt = thr;
            else                 cnt_nxt = cnt + 1'b1;
        end
        qual_o = upd && ev && (cnt_nxt == thr);
        hit_o  = (cnt != '0) && (cnt >= thr);
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    a_r4_clean_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !ev) |=> (cnt == '0));

    a_r5_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ev && cnt >= thr) |=> (cnt == $past(thr)));

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ev && cnt < thr) |=> (cnt == $past(cnt) + 1'b1));

    a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_THR);

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(cnt));

endmodule

// File: rtl/sticky_flags.sv
// Module: sticky_flags
// A vector of sticky bits. The bits are set by pulses and cleared by a clear
// pulse at the next edge; a set on that same edge wins. Assumes clr is one cycle.
module sticky_flags #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);

    // Hold, clear and set, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (clr ? '0 : q) | set;
    end

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((q & $past(set)) == $past(set)));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set == '0) |=> (q == '0));

endmodule

// File: rtl/temp_alert_filter.sv
// Module: temp_alert_filter (top)
// Per-channel consecutive-event filter for the alert and thermal outputs,
// with sticky status and fault registers. Assumes at most one measurement
// strobe per cycle and NCH >= 2.
module temp_alert_filter
    import tmp_alert_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_valid,
    input  logic [CHW-1:0]   meas_ch,
    input  logic [DW-1:0]    meas_value,
    input  logic             meas_fault,
    input  logic [DW-1:0]    hi_lim,
    input  logic [DW-1:0]    lo_lim,
    input  logic [DW-1:0]    th_lim,
    input  logic [SEL_W-1:0] alert_sel,
    input  logic [SEL_W-1:0] therm_sel,
    input  logic [NCH-1:0]   alert_mask,
    input  logic             rd_clr,
    output logic             alert_o,
    output logic             therm_o,
    output logic             rpt_valid,
    output logic [DW-1:0]    rpt_value,
    output logic [NCH-1:0]   status_hi,
    output logic [NCH-1:0]   status_lo,
    output logic [NCH-1:0]   fault_flags,
    output logic             fault_any
);

    evt_t           ev;
    logic [DW-1:0]  shown;
    logic [NCH-1:0] upd;
    logic [NCH-1:0] a_hit, a_qual;
    logic [NCH-1:0] t_hit, t_qual;
    logic [NCH-1:0] hi_set, lo_set, flt_set;

    limit_compare #(.DW(DW)) u_cmp (
        .value  (meas_value),
        .fault  (meas_fault),
        .hi_lim (hi_lim),
        .lo_lim (lo_lim),
        .th_lim (th_lim),
        .ev     (ev),
        .shown  (shown)
    );

    // Per-channel counter pair and status set pulses.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign upd[c] = meas_valid && (meas_ch == CHW'(c));

        event_debounce u_alert_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (upd[c]),
            .ev     (ev.hi || ev.lo || ev.flt),
            .sel    (alert_sel),
            .hit_o  (a_hit[c]),
            .qual_o (a_qual[c])
        );

        event_debounce u_therm_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (upd[c]),
            .ev     (ev.th),
            .sel    (therm_sel),
            .hit_o  (t_hit[c]),
            .qual_o (t_qual[c])
        );

        assign hi_set[c]  = a_qual[c] && ev.hi;
        assign lo_set[c]  = a_qual[c] && ev.lo;
        assign flt_set[c] = a_qual[c] && ev.flt;
    end

    sticky_flags #(.W(NCH)) u_st_hi (
        .clk(clk), .rst_n(rst_n), .set(hi_set), .clr(rd_clr), .q(status_hi));
    sticky_flags #(.W(NCH)) u_st_lo (
        .clk(clk), .rst_n(rst_n), .set(lo_set), .clr(rd_clr), .q(status_lo));
    sticky_flags #(.W(NCH)) u_st_flt (
        .clk(clk), .rst_n(rst_n), .set(flt_set), .clr(rd_clr), .q(fault_flags));

    // Output pins from the counter hits, alert pin masked per channel.
    always_comb begin
        alert_o   = |(a_hit & ~alert_mask);
        therm_o   = |t_hit;
        fault_any = |fault_flags;
    end

    // Registered reported reading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_valid <= 1'b0;
            rpt_value <= '0;
        end else begin
            rpt_valid <= meas_valid;
            if (meas_valid) rpt_value <= shown;
        end
    end

    a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas_fault) |=> (rpt_valid && rpt_value == '0));

    a_r6_fault_no_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas_fault && !rd_clr && status_lo == '0) |=> (status_lo == '0));

    a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&alert_mask) |-> !alert_o);

    a_r10_fault_any: assert property (@(posedge clk) disable iff (!rst_n)
        fault_any == (fault_flags != '0));

endmodule

// File: tb/temp_alert_filter_bench.sv
module temp_alert_filter_bench;

    localparam int NCH = 4;
    localparam int DW  = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           meas_valid = 1'b0;
    logic [1:0]     meas_ch = '0;
    logic [DW-1:0]  meas_value = '0;
    logic           meas_fault = 1'b0;
    logic [DW-1:0]  hi_lim = 8'd80;
    logic [DW-1:0]  lo_lim = 8'd20;
    logic [DW-1:0]  th_lim = 8'd100;
    logic [2:0]     alert_sel = 3'b000;
    logic [2:0]     therm_sel = 3'b000;
    logic [NCH-1:0] alert_mask = '0;
    logic           rd_clr = 1'b0;
    logic           alert_o, therm_o, rpt_valid, fault_any;
    logic [DW-1:0]  rpt_value;
    logic [NCH-1:0] status_hi, status_lo, fault_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    temp_alert_filter #(.NCH(NCH), .DW(DW)) u_temp_alert_filter (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_ch(meas_ch),
        .meas_value(meas_value), .meas_fault(meas_fault), .hi_lim(hi_lim),
        .lo_lim(lo_lim), .th_lim(th_lim), .alert_sel(alert_sel),
        .therm_sel(therm_sel), .alert_mask(alert_mask), .rd_clr(rd_clr),
        .alert_o(alert_o), .therm_o(therm_o), .rpt_valid(rpt_valid),
        .rpt_value(rpt_value), .status_hi(status_hi), .status_lo(status_lo),
        .fault_flags(fault_flags), .fault_any(fault_any)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One measurement strobe; returns at the negedge after the update edge.
    task automatic meas(input int ch, input int v, input bit f);
        @(negedge clk);
        meas_valid = 1'b1; meas_ch = 2'(ch); meas_value = 8'(v); meas_fault = f;
        @(negedge clk);
        meas_valid = 1'b0; meas_fault = 1'b0;
    endtask

    task automatic clear_status();
        @(negedge clk); rd_clr = 1'b1;
        @(negedge clk); rd_clr = 1'b0;
    endtask

    task automatic clean_all();
        for (int c = 0; c < NCH; c++) meas(c, 50, 1'b0);
        clear_status();
    endtask

    task automatic t_reset();
        check("R12 alert", alert_o, 0);
        check("R12 therm", therm_o, 0);
        check("R12 status", {status_hi, status_lo, fault_flags}, 0);
        check("R12 rpt", {rpt_valid, rpt_value}, 0);
    endtask

    task automatic t_count3();
        clean_all();
        alert_sel = 3'b011;
        meas(0, 90, 0);
        check("R2 sel011 after 1", alert_o, 0);
        meas(0, 90, 0);
        check("R2 sel011 after 2", alert_o, 0);
        check("R9 no status before qualify", status_hi, 0);
        meas(0, 90, 0);
        check("R2 sel011 after 3", alert_o, 1);
        check("R9 status_hi latched", status_hi, 4'b0001);
        check("R6 reported value", rpt_value, 90);
        meas(0, 95, 0);
        check("R5 saturated stays high", alert_o, 1);
        meas(0, 50, 0);
        check("R4 clean drops alert", alert_o, 0);
        check("R11 status sticky", status_hi, 4'b0001);
        clear_status();
        check("R11 read clear", status_hi, 0);
    endtask

    task automatic t_interleave();
        clean_all();
        alert_sel = 3'b001;
        meas(1, 90, 0);
        meas(2, 90, 0);
        check("R3 partial counts", alert_o, 0);
        meas(1, 90, 0);
        check("R3 ch1 reaches 2 across ch2", alert_o, 1);
        meas(1, 50, 0);
        check("R3 ch2 partial does not fire", alert_o, 0);
        meas(2, 90, 0);
        check("R3 ch2 reaches 2", alert_o, 1);
        meas(2, 50, 0);
    endtask

    task automatic t_limits();
        clean_all();
        alert_sel = 3'b000;
        meas(0, 80, 0);
        check("R1 equal high", alert_o, 0);
        meas(0, 20, 0);
        check("R1 equal low", alert_o, 0);
        meas(0, 19, 0);
        check("R1 below low", alert_o, 1);
        check("R9 status_lo", status_lo, 4'b0001);
        meas(0, 81, 0);
        check("R1 above high", alert_o, 1);
        check("R9 status_hi", status_hi, 4'b0001);
        meas(0, 50, 0);
    endtask

    task automatic t_encodings();
        clean_all();
        alert_sel = 3'b101;
        meas(3, 90, 0);
        check("R2 sel101 means 1", alert_o, 1);
        meas(3, 50, 0);
        alert_sel = 3'b111;
        for (int i = 0; i < 3; i++) meas(3, 90, 0);
        check("R2 sel111 not at 3", alert_o, 0);
        meas(3, 90, 0);
        check("R2 sel111 at 4", alert_o, 1);
        meas(3, 50, 0);
    endtask

    task automatic t_fault();
        clean_all();
        alert_sel = 3'b000; therm_sel = 3'b000;
        meas(3, 5, 1);
        check("R6 value forced zero", rpt_value, 0);
        check("R6 rpt_valid", rpt_valid, 1);
        check("R6 fault is event", alert_o, 1);
        check("R6 fault drives therm", therm_o, 1);
        check("R6 low check skipped", status_lo, 0);
        check("R10 fault flag ch3", fault_flags, 4'b1000);
        check("R10 fault_any", fault_any, 1);
        meas(3, 50, 0);
        check("R4 clean after fault", {alert_o, therm_o}, 0);
        clear_status();
        check("R11 fault cleared", {fault_any, fault_flags}, 0);
    endtask

    task automatic t_mask();
        clean_all();
        alert_sel = 3'b000;
        alert_mask = 4'b0001;
        meas(0, 90, 0);
        check("R7 masked no alert", alert_o, 0);
        check("R7 masked status still set", status_hi, 4'b0001);
        @(negedge clk); alert_mask = 4'b0000;
        #1;
        check("R7 unmask exposes", alert_o, 1);
        meas(0, 50, 0);
    endtask

    task automatic t_therm();
        clean_all();
        alert_sel = 3'b111; therm_sel = 3'b001;
        meas(2, 110, 0);
        check("R8 therm after 1", therm_o, 0);
        meas(2, 110, 0);
        check("R8 therm after 2", therm_o, 1);
        check("R8 alert independent", alert_o, 0);
        meas(2, 110, 0);
        meas(2, 110, 0);
        check("R8 alert at 4", alert_o, 1);
        meas(2, 90, 0);
        check("R8 below therm limit clears therm", therm_o, 0);
        meas(2, 50, 0);
        therm_sel = 3'b000;
    endtask

    task automatic t_clear_race();
        clean_all();
        alert_sel = 3'b000;
        meas(0, 10, 0);
        check("R9 pre status_lo", status_lo, 4'b0001);
        @(negedge clk);
        rd_clr = 1'b1; meas_valid = 1'b1; meas_ch = 2'd1; meas_value = 8'd90;
        @(negedge clk);
        rd_clr = 1'b0; meas_valid = 1'b0;
        check("R11 set wins on clear edge", status_hi, 4'b0010);
        check("R11 other bits cleared", status_lo, 0);
        meas(1, 50, 0);
        meas(0, 50, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count3();
        t_interleave();
        t_limits();
        t_encodings();
        t_fault();
        t_mask();
        t_therm();
        t_clear_race();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule